// File: doc/BRIEF.md
# Tracking Up/Down Counter Converter Core

This block is the digital half of a servo-style tracking analog-to-digital converter. It owns an up/down counter whose value drives an external DAC. An external comparator reports whether the analog input sits above the DAC level. On every clock the counter moves one code toward the input, so the code follows a slowly changing signal without restarting a conversion for each sample. Since the count moves by at most one LSB per clock, only inputs that change slowly compared with the clock are followed faithfully.

A hold input stops the counter and the output register, so the last code stays as long as needed, as a sample-and-hold would. Two direction disables turn the tracker into a peak recorder. With upward steps blocked, the count only falls, so it keeps the lowest level seen. With downward steps blocked, it keeps the highest. A synchronous clear loads a code given on an input. All-ones is the natural start for minimum capture and zero for maximum capture. A valid flag rises once the comparator has reversed direction twice, which shows that the loop has settled into one-LSB dither.

Top module: `servo_track_adc`

## Requirements
- R1: When reset is applied (rst_n low at a clock edge), dac_code becomes 0, held_code becomes 0 and valid becomes 0.
- R2: In a tracking cycle (clr low, hold low), dac_code rises by one when cmp_hi is 1 (input above DAC) and falls by one when cmp_hi is 0.
- R3: dac_code saturates: it stays at 2^W-1 on an upward request and stays at 0 on a downward request, and it never wraps.
- R4: While hold is high and clr is low, dac_code and held_code keep their values whatever cmp_hi does.
- R5: With up_dis high, an upward request leaves dac_code unchanged while downward steps still occur, so the code keeps the minimum that was reached.
- R6: With dn_dis high, a downward request leaves dac_code unchanged while upward steps still occur, so the code keeps the maximum that was reached.
- R7: With clr high, dac_code loads init_code on the next edge, even while hold is high, and valid returns to 0.
- R8: After every edge with hold low, held_code equals dac_code. After an edge with hold high, held_code keeps its previous value, even when clr loads the counter.
- R9: valid becomes 1 after the edge at which cmp_hi has reversed for the second time. A reversal is a change between successive tracking cycles since the last clear or reset. Cycles with hold high neither count as reversals nor clear valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous load of init_code into the counter |
| init_code | input | W | Value loaded by clr |
| hold | input | 1 | Freeze counter and output register |
| up_dis | input | 1 | Block upward steps (minimum capture) |
| dn_dis | input | 1 | Block downward steps (maximum capture) |
| cmp_hi | input | 1 | Comparator: 1 when the analog input exceeds the DAC level |
| dac_code | output | W | Counter value driving the DAC |
| held_code | output | W | Output register, frozen while hold is high |
| valid | output | 1 | Loop has settled (two direction reversals seen) |

## Verification
The counter is driven with runs of cmp_hi in one direction, which show the one-step slope. Alternating cmp_hi patterns show the dither that must raise valid after exactly the second reversal, and not after the first. Sequences with up_dis or dn_dis held high are mixed with reversals, so they tell a blocked step apart from a step in the allowed direction. Clears to codes next to zero and next to all-ones push the counter against both rails to expose any wrap. A clear during hold separates the counter from the output register.

// File: rtl/servo_pkg.sv
// Package: shared step encoding for the tracking converter core.
// Assumes nothing beyond being compiled first.
package servo_pkg;
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;
endpackage

// File: rtl/servo_step_ctl.sv
// Module: servo_step_ctl
// Decides the counter move for this cycle from the comparator, the
// hold and direction-disable controls and the saturation rails.
// Assumes clr is handled by the counter register, which gives it priority.
module servo_step_ctl
    import servo_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         hold,
    input  logic         up_dis,
    input  logic         dn_dis,
    input  logic         cmp_hi,
    input  logic [W-1:0] count,
    output step_e        step
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = '0;

    // Pick a step that respects hold, the disables and the rails.
    always_comb begin
        step = STEP_NONE;
        if (!hold) begin
            if (cmp_hi) begin
                if (!up_dis && count != TOP) step = STEP_UP;
            end else begin
                if (!dn_dis && count != BOT) step = STEP_DN;
            end
        end
    end
endmodule

// File: rtl/servo_updown_reg.sv
// Module: servo_updown_reg
// Holds the tracking count and the output register. clr overrides
// the step; the output register follows the next count unless hold is high.
// Assumes the step input never asks to leave the code range.
module servo_updown_reg
    import servo_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         hold,
    input  logic [W-1:0] init_code,
    input  step_e        step,
    output logic [W-1:0] count,
    output logic [W-1:0] held
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] count_nx;

    // Next count: a load wins over a step.
    always_comb begin
        if (clr) begin
            count_nx = init_code;
        end else begin
            unique case (step)
                STEP_UP: count_nx = count + ONE;
                STEP_DN: count_nx = count - ONE;
                default: count_nx = count;
            endcase
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nx;
    end

    // Output register, frozen while hold is high.
    always_ff @(posedge clk) begin
        if (!rst_n)     held <= '0;
        else if (!hold) held <= count_nx;
    end
endmodule

// File: rtl/servo_settle_mon.sv
// Module: servo_settle_mon
// Counts reversals of the comparator between successive tracking cycles
// and flags settling after REVERSALS of them. Clear and reset restart it.
// Assumes REVERSALS is at least 1.
module servo_settle_mon #(
    parameter int REVERSALS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic track_en,
    input  logic dir,
    output logic settled
);
    localparam int CW = $clog2(REVERSALS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(REVERSALS);

    logic          have_prev;
    logic          prev_dir;
    logic [CW-1:0] rev_cnt;

    // Remember the last tracking direction and count reversals up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            have_prev <= 1'b0;
            prev_dir  <= 1'b0;
            rev_cnt   <= '0;
        end else if (track_en) begin
            have_prev <= 1'b1;
            prev_dir  <= dir;
            if (have_prev && dir != prev_dir && rev_cnt != LIMIT)
                rev_cnt <= rev_cnt + 1'b1;
        end
    end

    assign settled = (rev_cnt == LIMIT);
endmodule

// File: rtl/servo_track_adc.sv
// Module: servo_track_adc (top)
// Digital core of a tracking converter: an up/down counter that follows
// the comparator, with hold, minimum/maximum capture and settle flag.
// Assumes cmp_hi is already synchronous to clk.
module servo_track_adc
    import servo_pkg::*;
#(
    parameter int W         = 8,
    parameter int REVERSALS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] init_code,
    input  logic         hold,
    input  logic         up_dis,
    input  logic         dn_dis,
    input  logic         cmp_hi,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] held_code,
    output logic         valid
);
    step_e step;
    logic  track_en;

    // A cycle tracks when neither a load nor a freeze is requested.
    assign track_en = !clr && !hold;

    servo_step_ctl #(.W(W)) u_step (
        .hold   (hold),
        .up_dis (up_dis),
        .dn_dis (dn_dis),
        .cmp_hi (cmp_hi),
        .count  (dac_code),
        .step   (step)
    );

    servo_updown_reg #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .hold      (hold),
        .init_code (init_code),
        .step      (step),
        .count     (dac_code),
        .held      (held_code)
    );

    servo_settle_mon #(.REVERSALS(REVERSALS)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .track_en (track_en),
        .dir      (cmp_hi),
        .settled  (valid)
    );
endmodule

// File: rtl/servo_track_chk.sv
// Module: servo_track_chk
// Port-level properties of the tracking core, bound to the top.
module servo_track_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic [W-1:0] init_code,
    input logic         hold,
    input logic         up_dis,
    input logic         dn_dis,
    input logic         cmp_hi,
    input logic [W-1:0] dac_code,
    input logic [W-1:0] held_code,
    input logic         valid
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hold && cmp_hi && !up_dis && dac_code != TOP)
        |=> dac_code == $past(dac_code) + ONE);

    // R3
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && dac_code == TOP) |=> dac_code != '0);

    // R3
    no_wrap_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && dac_code == '0) |=> dac_code != TOP);

    // R4
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(dac_code) && $stable(held_code));

    // R5
    min_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_dis && !clr) |=> dac_code <= $past(dac_code));

    // R6
    max_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_dis && !clr) |=> dac_code >= $past(dac_code));

    // R7
    clear_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dac_code == $past(init_code)) && !valid);

    // R8
    held_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> held_code == dac_code);
endmodule

bind servo_track_adc servo_track_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .init_code (init_code),
    .hold      (hold),
    .up_dis    (up_dis),
    .dn_dis    (dn_dis),
    .cmp_hi    (cmp_hi),
    .dac_code  (dac_code),
    .held_code (held_code),
    .valid     (valid)
);

// File: tb/tb_servo_track_adc.sv
// Bench for servo_track_adc: a vector table walked by one loop, then
// directed reset checks.
module tb_servo_track_adc;
    localparam int W  = 8;
    localparam int NV = 23;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         clr;
    logic [W-1:0] init_code;
    logic         hold;
    logic         up_dis;
    logic         dn_dis;
    logic         cmp_hi;
    logic [W-1:0] dac_code;
    logic [W-1:0] held_code;
    logic         valid;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #2 clk = ~clk;

    servo_track_adc #(.W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .init_code (init_code),
        .hold      (hold),
        .up_dis    (up_dis),
        .dn_dis    (dn_dis),
        .cmp_hi    (cmp_hi),
        .dac_code  (dac_code),
        .held_code (held_code),
        .valid     (valid)
    );

    // Vector: {clr, hold, up_dis, dn_dis, cmp_hi, init, exp_code, exp_held, exp_valid}
    localparam logic [29:0] VEC [NV] = '{
        {5'b10000, 8'd5,   8'd5,   8'd5,   1'b0}, // R7 load 5
        {5'b00001, 8'd0,   8'd6,   8'd6,   1'b0}, // R2 up
        {5'b00001, 8'd0,   8'd7,   8'd7,   1'b0}, // R2 up
        {5'b00000, 8'd0,   8'd6,   8'd6,   1'b0}, // R9 first reversal
        {5'b00001, 8'd0,   8'd7,   8'd7,   1'b1}, // R9 second reversal
        {5'b00000, 8'd0,   8'd6,   8'd6,   1'b1}, // R2 down
        {5'b01001, 8'd0,   8'd6,   8'd6,   1'b1}, // R4 hold
        {5'b01000, 8'd0,   8'd6,   8'd6,   1'b1}, // R4 hold
        {5'b11000, 8'd200, 8'd200, 8'd6,   1'b0}, // R8 clear under hold
        {5'b00101, 8'd0,   8'd200, 8'd200, 1'b0}, // R5 up blocked
        {5'b00100, 8'd0,   8'd199, 8'd199, 1'b0}, // R5 down
        {5'b00100, 8'd0,   8'd198, 8'd198, 1'b0}, // R5 down
        {5'b00101, 8'd0,   8'd198, 8'd198, 1'b1}, // R5 minimum kept
        {5'b10000, 8'd0,   8'd0,   8'd0,   1'b0}, // R7 load 0
        {5'b00010, 8'd0,   8'd0,   8'd0,   1'b0}, // R6 down blocked
        {5'b00011, 8'd0,   8'd1,   8'd1,   1'b0}, // R6 up
        {5'b00010, 8'd0,   8'd1,   8'd1,   1'b1}, // R6 maximum kept
        {5'b00000, 8'd0,   8'd0,   8'd0,   1'b1}, // R2 down
        {5'b00000, 8'd0,   8'd0,   8'd0,   1'b1}, // R3 floor
        {5'b10000, 8'd254, 8'd254, 8'd254, 1'b0}, // R7 load 254
        {5'b00001, 8'd0,   8'd255, 8'd255, 1'b0}, // R2 up
        {5'b00001, 8'd0,   8'd255, 8'd255, 1'b0}, // R3 ceiling
        {5'b00001, 8'd0,   8'd255, 8'd255, 1'b0}  // R3 ceiling
    };

    function automatic string tag_of(int i);
        case (i)
            0, 13, 19:       return "R7";
            3, 4:            return "R9";
            6, 7:            return "R4";
            8:               return "R8";
            9, 10, 11, 12:   return "R5";
            14, 15, 16:      return "R6";
            18, 21, 22:      return "R3";
            default:         return "R2";
        endcase
    endfunction

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0; clr = 1'b0; init_code = '0; hold = 1'b0;
        up_dis = 1'b0; dn_dis = 1'b0; cmp_hi = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "dac_code", dac_code, 8'd0);
        check("R1", "held_code", held_code, 8'd0);
        check("R1", "valid", {7'd0, valid}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {clr, hold, up_dis, dn_dis, cmp_hi} = VEC[i][29:25];
            init_code = VEC[i][24:17];
            @(posedge clk);
            #1;
            check(tag_of(i), "dac_code", dac_code, VEC[i][16:9]);
            check(tag_of(i), "held_code", held_code, VEC[i][8:1]);
            check(tag_of(i), "valid", {7'd0, valid}, {7'd0, VEC[i][0]});
            @(negedge clk);
        end

        // R1: reset in mid-run returns to zero from the ceiling.
        clr = 1'b0; hold = 1'b0; up_dis = 1'b0; dn_dis = 1'b0; cmp_hi = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "dac_code after reset", dac_code, 8'd0);
        check("R1", "held_code after reset", held_code, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: one reversal alone must not raise valid.
        cmp_hi = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmp_hi = 1'b0;
        @(posedge clk);
        #1;
        check("R9", "valid after one reversal", {7'd0, valid}, 8'd0);
        check("R2", "dac_code up then down", dac_code, 8'd0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule